// File: doc/BRIEF.md
# ADC Result and Status Register Bank

This block sits between an analog-to-digital conversion sequencer and a processor bus. Each time the sequencer finishes a conversion it pulses a completion strobe that carries the 12-bit result and the 3-bit index of the channel that was sampled. The block latches both values into a global result word and sets a completion flag in the same word. If a new result lands while the previous one is still unread and the sequencer is running in burst mode, an overrun flag is raised as well. A bus read of the result word clears both flags, so software polls or takes an interrupt, reads once, and is ready for the next sample.

A second register holds one interrupt enable bit per channel. The interrupt line is a level that stays high while a result is pending and the enable bit for the channel recorded in the result word is set. When software writes the converter's control register, the sequencer reports the write to this block. If no conversion is running, that write clears the completion flag. If a conversion is running, the completion flag is set and a one-cycle restart pulse asks the sequencer to begin a new conversion.

The flags are kept by a four-state machine. The states are `ST_EMPTY` (no result pending, no overrun), `ST_FRESH` (result pending, no overrun), `ST_LOST` (result pending with overrun) and `ST_STALE_OV` (no result pending, overrun not yet reported). The completion strobe takes priority over a result-word read, and a read takes priority over a control write. The transitions are:
- **capture**: a strobe moves `ST_EMPTY` to `ST_FRESH` and `ST_STALE_OV` to `ST_LOST`. It also moves `ST_FRESH` to `ST_LOST` in burst mode, keeps `ST_FRESH` otherwise, and keeps `ST_LOST`.
- **drain**: a result-word read moves any state to `ST_EMPTY`.
- **discard**: a control write while idle moves `ST_FRESH` to `ST_EMPTY` and `ST_LOST` to `ST_STALE_OV`.
- **rearm**: a control write during a conversion moves `ST_EMPTY` to `ST_FRESH` and `ST_STALE_OV` to `ST_LOST`.

Top module: `adc_status_regs`

## Requirements
- R1: A completion strobe loads the result into bits 15:4 and the channel index, as plain binary (0 is channel 0), into bits 26:24 of the result word at word address 0. Result 0x000 and 0xFFF are both stored unchanged.
- R2: The completion flag is bit 31 of the result word. A strobe sets it. A bus read of word address 0 clears it and the overrun flag (bit 30) on the clock edge that ends the read.
- R3: The overrun flag (bit 30) is set only by a strobe that arrives while the completion flag is 1 and `burst_en` is 1. A control write does not clear it. Only a result-word read clears it.
- R4: A control write with `cvt_busy` low clears the completion flag. With `cvt_busy` high it sets the completion flag and drives `cvt_restart` high for exactly the following cycle.
- R5: When a strobe and a result-word read (or a control write) occur in the same cycle, the read returns the old word and the completion flag is 1 afterwards, holding the new result.
- R6: The interrupt enable register is at word address 1. Bit n enables channel n, the bits are read/write, and they reset to 0.
- R7: `irq` is high exactly while the completion flag is 1 and the enable bit selected by the stored channel field is 1. It falls in the cycle the completion flag is cleared.
- R8: Reserved bits of the result word (3:0, 23:16, 29:27), bits 31:8 of the enable word and every bit of word addresses 2 and 3 read as 0. Writes to addresses 0, 2 and 3 have no effect.
- R9: After reset both words read 0 and `irq` and `cvt_restart` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Word address of the bus access |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, valid in the cycle of the access |
| cvt_valid | input | 1 | Conversion-complete strobe |
| cvt_result | input | 12 | Conversion result carried by the strobe |
| cvt_chan | input | 3 | Channel index carried by the strobe |
| burst_en | input | 1 | Sequencer is in burst mode |
| ctrl_wr | input | 1 | Converter control register was written |
| cvt_busy | input | 1 | A conversion is in progress |
| cvt_restart | output | 1 | One-cycle request to start a new conversion |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest situations to reach from the ports are the coincidences. One is a strobe that lands in the same cycle as the read meant to drain the previous result. The other is an overrun that has been detected but then hidden by a control write, which leaves the machine in `ST_STALE_OV` with nothing visible on `irq`. The stimulus reaches these by driving the strobe, the read and the control write in one shared cycle from a single task. It then drains the word with a following read, so the overrun bit that survived becomes visible on the bus. A sweep over all eight channels, each with three enable patterns, checks the channel-to-enable selection behind the interrupt.

// File: rtl/adc_regs_pkg.sv
package adc_regs_pkg;

    // Flag machine states; bit 0 mirrors the completion flag, bit 1 the overrun flag
    typedef enum logic [1:0] {
        ST_EMPTY    = 2'b00,
        ST_FRESH    = 2'b01,
        ST_STALE_OV = 2'b10,
        ST_LOST     = 2'b11
    } flag_state_t;

    // Field placement inside the result word (decoded by software, so fixed)
    localparam int RES_LSB  = 4;
    localparam int CHN_LSB  = 24;
    localparam int OVR_BIT  = 30;
    localparam int DONE_BIT = 31;

    // Word addresses
    localparam int unsigned WORD_GDR   = 0;
    localparam int unsigned WORD_INTEN = 1;

endpackage

// File: rtl/adc_flag_fsm.sv
module adc_flag_fsm
    import adc_regs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cvt_valid,
    input  logic burst_en,
    input  logic gdr_read,
    input  logic ctrl_wr,
    input  logic cvt_busy,
    output logic done_flag,
    output logic ovr_flag,
    output logic restart_pulse
);

    flag_state_t state_q;
    flag_state_t state_d;
    logic        restart_q;

    // Next-state: strobe beats read, read beats control write
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (cvt_valid) begin
                    state_d = ST_FRESH;
                end else if (gdr_read) begin
                    state_d = ST_EMPTY;
                end else if (ctrl_wr && cvt_busy) begin
                    state_d = ST_FRESH;
                end
            end
            ST_FRESH: begin
                if (cvt_valid) begin
                    state_d = burst_en ? ST_LOST : ST_FRESH;
                end else if (gdr_read) begin
                    state_d = ST_EMPTY;
                end else if (ctrl_wr) begin
                    state_d = cvt_busy ? ST_FRESH : ST_EMPTY;
                end
            end
            ST_LOST: begin
                if (cvt_valid) begin
                    state_d = ST_LOST;
                end else if (gdr_read) begin
                    state_d = ST_EMPTY;
                end else if (ctrl_wr) begin
                    state_d = cvt_busy ? ST_LOST : ST_STALE_OV;
                end
            end
            ST_STALE_OV: begin
                if (cvt_valid) begin
                    state_d = ST_LOST;
                end else if (gdr_read) begin
                    state_d = ST_EMPTY;
                end else if (ctrl_wr && cvt_busy) begin
                    state_d = ST_LOST;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_EMPTY;
            restart_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            restart_q <= ctrl_wr && cvt_busy;
        end
    end

    // Outputs decoded from state
    always_comb begin
        done_flag = 1'b0;
        ovr_flag  = 1'b0;
        unique case (state_q)
            ST_EMPTY:    begin done_flag = 1'b0; ovr_flag = 1'b0; end
            ST_FRESH:    begin done_flag = 1'b1; ovr_flag = 1'b0; end
            ST_STALE_OV: begin done_flag = 1'b0; ovr_flag = 1'b1; end
            ST_LOST:     begin done_flag = 1'b1; ovr_flag = 1'b1; end
        endcase
        restart_pulse = restart_q;
    end

endmodule

// File: rtl/adc_result_capture.sv
module adc_result_capture #(
    parameter int RES_W = 12,
    parameter int CH_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cvt_valid,
    input  logic [RES_W-1:0] cvt_result,
    input  logic [CH_W-1:0]  cvt_chan,
    output logic [RES_W-1:0] res_q,
    output logic [CH_W-1:0]  chan_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            chan_q <= '0;
        end else if (cvt_valid) begin
            res_q  <= cvt_result;
            chan_q <= cvt_chan;
        end
    end

endmodule

// File: rtl/adc_chan_irq.sv
module adc_chan_irq #(
    parameter int CH_W = 3,
    parameter int NCH  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_wr,
    input  logic [NCH-1:0]  en_wdata,
    input  logic            done_flag,
    input  logic [CH_W-1:0] chan_q,
    output logic [NCH-1:0]  en_q,
    output logic            irq
);

    // One enable flop per channel
    for (genvar g = 0; g < NCH; g++) begin : g_en
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[g] <= 1'b0;
            end else if (en_wr) begin
                en_q[g] <= en_wdata[g];
            end
        end
    end

    assign irq = done_flag && en_q[chan_q];

endmodule

// File: rtl/adc_read_mux.sv
module adc_read_mux
    import adc_regs_pkg::*;
#(
    parameter int RES_W  = 12,
    parameter int CH_W   = 3,
    parameter int NCH    = 8,
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [RES_W-1:0]  res_q,
    input  logic [CH_W-1:0]   chan_q,
    input  logic              done_flag,
    input  logic              ovr_flag,
    input  logic [NCH-1:0]    en_q,
    output logic [DATA_W-1:0] bus_rdata
);

    logic [DATA_W-1:0] gdr_word;
    logic [DATA_W-1:0] en_word;

    always_comb begin
        gdr_word                       = '0;
        gdr_word[RES_LSB +: RES_W]     = res_q;
        gdr_word[CHN_LSB +: CH_W]      = chan_q;
        gdr_word[OVR_BIT]              = ovr_flag;
        gdr_word[DONE_BIT]             = done_flag;
        en_word                        = '0;
        en_word[NCH-1:0]               = en_q;
    end

    always_comb begin
        if (bus_addr == ADDR_W'(WORD_GDR)) begin
            bus_rdata = gdr_word;
        end else if (bus_addr == ADDR_W'(WORD_INTEN)) begin
            bus_rdata = en_word;
        end else begin
            bus_rdata = '0;
        end
    end

endmodule

// File: rtl/adc_status_regs.sv
module adc_status_regs
    import adc_regs_pkg::*;
#(
    parameter int RES_W  = 12,
    parameter int CH_W   = 3,
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cvt_valid,
    input  logic [RES_W-1:0]  cvt_result,
    input  logic [CH_W-1:0]   cvt_chan,
    input  logic              burst_en,
    input  logic              ctrl_wr,
    input  logic              cvt_busy,
    output logic              cvt_restart,
    output logic              irq
);

    localparam int NCH = 1 << CH_W;

    logic             gdr_read;
    logic             en_wr;
    logic             done_flag;
    logic             ovr_flag;
    logic [RES_W-1:0] res_q;
    logic [CH_W-1:0]  chan_q;
    logic [NCH-1:0]   en_q;

    assign gdr_read = bus_rd && (bus_addr == ADDR_W'(WORD_GDR));
    assign en_wr    = bus_wr && (bus_addr == ADDR_W'(WORD_INTEN));

    adc_flag_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cvt_valid     (cvt_valid),
        .burst_en      (burst_en),
        .gdr_read      (gdr_read),
        .ctrl_wr       (ctrl_wr),
        .cvt_busy      (cvt_busy),
        .done_flag     (done_flag),
        .ovr_flag      (ovr_flag),
        .restart_pulse (cvt_restart)
    );

    adc_result_capture #(.RES_W(RES_W), .CH_W(CH_W)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .cvt_valid  (cvt_valid),
        .cvt_result (cvt_result),
        .cvt_chan   (cvt_chan),
        .res_q      (res_q),
        .chan_q     (chan_q)
    );

    adc_chan_irq #(.CH_W(CH_W), .NCH(NCH)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_wr     (en_wr),
        .en_wdata  (bus_wdata[NCH-1:0]),
        .done_flag (done_flag),
        .chan_q    (chan_q),
        .en_q      (en_q),
        .irq       (irq)
    );

    adc_read_mux #(
        .RES_W(RES_W), .CH_W(CH_W), .NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_mux (
        .bus_addr  (bus_addr),
        .res_q     (res_q),
        .chan_q    (chan_q),
        .done_flag (done_flag),
        .ovr_flag  (ovr_flag),
        .en_q      (en_q),
        .bus_rdata (bus_rdata)
    );

endmodule

// File: rtl/adc_status_regs_chk.sv
module adc_status_regs_chk #(
    parameter int RES_W  = 12,
    parameter int CH_W   = 3,
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              cvt_valid,
    input logic [RES_W-1:0]  cvt_result,
    input logic [CH_W-1:0]   cvt_chan,
    input logic              burst_en,
    input logic              ctrl_wr,
    input logic              cvt_busy,
    input logic              cvt_restart,
    input logic              irq,
    input logic              done_flag,
    input logic              ovr_flag,
    input logic [RES_W-1:0]  res_q,
    input logic [CH_W-1:0]   chan_q
);

    localparam logic [DATA_W-1:0] USED_MASK =
        (((DATA_W'(1) << RES_W) - DATA_W'(1)) << 4) |
        (((DATA_W'(1) << CH_W) - DATA_W'(1)) << 24) |
        (DATA_W'(3) << 30);

    logic rd_gdr;
    assign rd_gdr = bus_rd && (bus_addr == '0);

    p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cvt_valid |=> (res_q == $past(cvt_result)) && (chan_q == $past(cvt_chan)));

    p_done_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cvt_valid |=> done_flag);

    p_read_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_gdr && !cvt_valid) |=> (!done_flag && !ovr_flag));

    p_ovr_burst_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> $past(burst_en && cvt_valid && done_flag));

    p_ctrl_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !cvt_busy && !cvt_valid && !rd_gdr) |=> !done_flag);

    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && cvt_busy) |=> cvt_restart);

    p_collide_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cvt_valid && (rd_gdr || ctrl_wr)) |=> done_flag);

    p_irq_needs_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done_flag);

    p_rsv_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == '0) |-> ((bus_rdata & ~USED_MASK) == '0));

endmodule

bind adc_status_regs adc_status_regs_chk #(
    .RES_W(RES_W), .CH_W(CH_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_rd      (bus_rd),
    .bus_rdata   (bus_rdata),
    .cvt_valid   (cvt_valid),
    .cvt_result  (cvt_result),
    .cvt_chan    (cvt_chan),
    .burst_en    (burst_en),
    .ctrl_wr     (ctrl_wr),
    .cvt_busy    (cvt_busy),
    .cvt_restart (cvt_restart),
    .irq         (irq),
    .done_flag   (done_flag),
    .ovr_flag    (ovr_flag),
    .res_q       (res_q),
    .chan_q      (chan_q)
);

// File: tb/adc_status_regs_tb_top.sv
module adc_status_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cvt_valid = 1'b0;
    logic [11:0] cvt_result = '0;
    logic [2:0]  cvt_chan = '0;
    logic        burst_en = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic        cvt_busy = 1'b0;
    logic        cvt_restart;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;

    // Bench model of the register state
    logic        m_done = 1'b0;
    logic        m_ovr = 1'b0;
    logic [11:0] m_res = '0;
    logic [2:0]  m_ch = '0;
    logic [7:0]  m_en = '0;

    always #5 clk = ~clk;

    adc_status_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cvt_valid(cvt_valid), .cvt_result(cvt_result), .cvt_chan(cvt_chan),
        .burst_en(burst_en), .ctrl_wr(ctrl_wr), .cvt_busy(cvt_busy),
        .cvt_restart(cvt_restart), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [1:0] a);
        if (a == 2'd0) return {m_done, m_ovr, 3'b000, m_ch, 8'h00, m_res, 4'h0};
        if (a == 2'd1) return {24'h0, m_en};
        return 32'h0;
    endfunction

    // One bus/strobe cycle; entered and left at a falling edge
    task automatic step(input logic v, input logic [11:0] r, input logic [2:0] c,
                        input logic burst, input logic rd, input logic [1:0] a,
                        input logic wr, input logic [31:0] wd,
                        input logic cw, input logic busy, input string tag);
        cvt_valid = v; cvt_result = r; cvt_chan = c; burst_en = burst;
        bus_rd = rd; bus_addr = a; bus_wr = wr; bus_wdata = wd;
        ctrl_wr = cw; cvt_busy = busy;
        #1;
        if (rd) chk({tag, " read"}, bus_rdata, exp_read(a));
        @(posedge clk);
        #1;
        if (wr && a == 2'd1) m_en = wd[7:0];
        if (v) begin
            m_ovr  = m_ovr | (burst & m_done);
            m_done = 1'b1;
            m_res  = r;
            m_ch   = c;
        end else if (rd && a == 2'd0) begin
            m_done = 1'b0;
            m_ovr  = 1'b0;
        end else if (cw) begin
            m_done = busy;
        end
        chk({tag, " R4 restart"}, {31'h0, cvt_restart}, {31'h0, cw && busy});
        chk({tag, " R7 irq"}, {31'h0, irq}, {31'h0, m_done && m_en[m_ch]});
        @(negedge clk);
        cvt_valid = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; ctrl_wr = 1'b0;
        cvt_busy = 1'b0; burst_en = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    endtask

    task automatic conv(input logic [11:0] r, input logic [2:0] c, input logic burst, input string tag);
        step(1'b1, r, c, burst, 1'b0, 2'd0, 1'b0, 32'h0, 1'b0, 1'b0, tag);
    endtask

    task automatic rd(input logic [1:0] a, input string tag);
        step(1'b0, 12'h0, 3'h0, 1'b0, 1'b1, a, 1'b0, 32'h0, 1'b0, 1'b0, tag);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input string tag);
        step(1'b0, 12'h0, 3'h0, 1'b0, 1'b0, a, 1'b1, d, 1'b0, 1'b0, tag);
    endtask

    task automatic ctl(input logic busy, input string tag);
        step(1'b0, 12'h0, 3'h0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0, 1'b1, busy, tag);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        bus_addr = 2'd0; #1;
        chk("R9 result word", bus_rdata, 32'h0);
        bus_addr = 2'd1; #1;
        chk("R9 enable word", bus_rdata, 32'h0);
        chk("R9 irq", {31'h0, irq}, 32'h0);
        chk("R9 restart", {31'h0, cvt_restart}, 32'h0);
        @(negedge clk);

        // R1 R6 R7 sweep: every channel under three enable patterns
        for (int ch = 0; ch < 8; ch++) begin
            for (int p = 0; p < 3; p++) begin
                logic [7:0]  pat;
                logic [11:0] res;
                pat = (p == 0) ? 8'(1 << ch) : (p == 1) ? ~8'(1 << ch) : 8'hFF;
                res = 12'((ch * 12'h249 + p * 12'h5A5) & 12'hFFF);
                if (ch == 0 && p == 0) res = 12'h000;
                if (ch == 7 && p == 2) res = 12'hFFF;
                wr(2'd1, {24'hABCDEF, pat}, "R6 enable write");
                rd(2'd1, "R6 enable readback");
                conv(res, 3'(ch), 1'b0, "R1 capture");
                rd(2'd0, "R1 R2 result word");
                chk("R2 irq after drain", {31'h0, irq}, 32'h0);
            end
        end

        // R3: back-to-back results with and without burst
        wr(2'd1, 32'hFF, "R6 enable all");
        conv(12'h111, 3'd1, 1'b0, "R3 first");
        conv(12'h222, 3'd2, 1'b0, "R3 second no burst");
        rd(2'd0, "R3 no overrun outside burst");
        conv(12'h333, 3'd3, 1'b1, "R3 first burst");
        conv(12'h444, 3'd4, 1'b1, "R3 second burst");
        rd(2'd0, "R3 overrun in burst");
        rd(2'd0, "R2 flags cleared by read");

        // R3 R4: overrun survives a control write; stale state
        conv(12'h555, 3'd5, 1'b1, "R3 stale a");
        conv(12'h666, 3'd6, 1'b1, "R3 stale b");
        ctl(1'b0, "R4 idle control write");
        chk("R4 irq dropped", {31'h0, irq}, 32'h0);
        ctl(1'b1, "R4 busy control write rearms");
        rd(2'd0, "R3 overrun kept after control write");

        // R4: busy control write from empty, then idle clears
        ctl(1'b1, "R4 busy from empty");
        rd(2'd0, "R4 done set by busy write");
        conv(12'h7A7, 3'd7, 1'b0, "R4 prep");
        ctl(1'b0, "R4 idle clears done");
        rd(2'd0, "R4 done cleared");

        // R5 collisions
        conv(12'h0F0, 3'd2, 1'b0, "R5 prep");
        step(1'b1, 12'h0E1, 3'd6, 1'b0, 1'b1, 2'd0, 1'b0, 32'h0, 1'b0, 1'b0, "R5 strobe with read");
        rd(2'd0, "R5 new result kept");
        step(1'b1, 12'hD2C, 3'd0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0, 1'b1, 1'b0, "R5 strobe with control write");
        rd(2'd0, "R5 done survives control write");

        // R8: reserved bits and ignored writes
        wr(2'd0, 32'hFFFF_FFFF, "R8 write to result word");
        rd(2'd0, "R8 result word untouched");
        wr(2'd2, 32'hFFFF_FFFF, "R8 write addr 2");
        wr(2'd3, 32'hFFFF_FFFF, "R8 write addr 3");
        rd(2'd2, "R8 addr 2 reads zero");
        rd(2'd3, "R8 addr 3 reads zero");
        wr(2'd1, 32'hFFFF_FF5A, "R8 enable upper bits");
        rd(2'd1, "R8 enable upper bits zero");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule